// File: doc/BRIEF.md
# Chained Descriptor Receive DMA

This block takes received frame bytes from a line receiver and places them into a shared memory. The memory holds a ring of descriptors that point to each other. Each descriptor occupies four consecutive memory words: word 0 is the address of the next descriptor, word 1 is the address of the data buffer, word 2 is the byte count that the block writes back, and word 3 is the status that the block writes back. The block starts at the descriptor named by its current-descriptor register. It fetches the two pointer words and stores the incoming bytes into the buffer, one byte in the low half of each memory word. It then writes the length word and the status word, and follows the chain pointer to the next descriptor.

Software keeps an end-descriptor register one step behind the descriptors it has handed to the block. The block never fills the descriptor that the end register names. If a frame arrives while the ring is exhausted, the block drops the frame and raises a buffer-overflow flag. It stays enabled and resumes as soon as software moves the end address. A frame longer than the programmed buffer length continues into the following descriptors. Only the last descriptor of a frame carries the end-of-message status bit and the frame's error bits. A status register holds event flags and the channel enable, and the interrupt line follows the enabled flags. A small counter counts completed frames.

Top module: `chained_rx_dma`

## Requirements
- R1: For each descriptor at address D, the block reads the chain pointer from D and the buffer address from D+1. It then writes the n-th byte of that buffer (counting from 0) to address buffer+n, as data {8'h00, byte}.
- R2: After the last byte of a buffer, the block writes the byte count to D+2 and then, in a later cycle, writes the status to D+3. No other write comes between them. The current-descriptor register (register 0) then reads back as the chain pointer.
- R3: A descriptor holds at most BUFLEN bytes (register 2, BUFLEN of 1 or more). A longer frame continues in the next descriptor. Status bit 7 (end of message) is set only in the descriptor that holds the frame's last byte. A frame that exactly fills a buffer uses one descriptor.
- R4: The status word is {8'h00, eom, 2'b00, err[4:0]}. The err bits are the rx_err value that comes with the last byte. They are 0 in descriptors that do not end a frame.
- R5: A byte that must start a new descriptor while the current-descriptor register equals the end register (register 1) causes several things. The block sets the overflow flag (DSR bit 6) and drops the rest of the frame, accepting its bytes without any memory write. The enable bit stays 1, and transfer resumes once the end register is moved.
- R6: When a descriptor completes and the chain pointer equals the end register, DSR bit 4 (end of transfer) is set. When a descriptor ending a frame completes, DSR bit 5 (end of message) is set.
- R7: A write to DSR (register 3) sets the enable bit from bit 0. It clears flag bits 7..4 that are written as 1, but only when bit 1 is also 1 in the same write. Without bit 1 the flags are unchanged. A flag that hardware sets in the same cycle as it is cleared stays set.
- R8: irq is high exactly when (DSR bit 5 and enable bit 5) or (DSR bit 6 and enable bit 6) holds. The interrupt-enable register is register 4.
- R9: The frame counter (register 6, CNT_W bits) increments once per frame that completes in a descriptor. Writing register 5 with bit 1 set clears the counter, and the clear wins over an increment in the same cycle. A wrap from all ones to 0 sets DSR bit 7.
- R10: While the enable bit is 0, rx_ready stays low and no memory access starts. Writing register 5 with bit 0 set has these effects: enable goes to 0, all flags and the counter go to 0, and the engine returns to idle.
- R11: After reset, registers 0 to 6 read 0, and irq and rx_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive byte present |
| rx_ready | output | 1 | Receive byte accepted this cycle |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | ERR_W | Frame error bits, valid with rx_last |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data returned next cycle |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can meet in one cycle: the engine setting the end-of-message flag while it writes a status word, and software clearing that same flag. To provoke this, the bench watches the memory port for the status write. In the cycle that write is visible, the bench issues a status-register clear of the end-of-message flag, so that both land on the same clock edge. The flag must read back as set afterwards. The frame counter wrap is also forced, and it must raise the counter-overflow flag together with the count reading zero.

// File: rtl/rxdma_pkg.sv
// Shared definitions for the chained receive DMA: engine states,
// register indices and bit positions of the register fields.
package rxdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RD_CP, S_RD_BP, S_LATCH, S_XFER, S_WR_LEN, S_WR_ST, S_DROP
    } eng_state_t;

    localparam logic [2:0] RA_CDA    = 3'd0;
    localparam logic [2:0] RA_EDA    = 3'd1;
    localparam logic [2:0] RA_BUFLEN = 3'd2;
    localparam logic [2:0] RA_DSR    = 3'd3;
    localparam logic [2:0] RA_IE     = 3'd4;
    localparam logic [2:0] RA_CMD    = 3'd5;
    localparam logic [2:0] RA_FCNT   = 3'd6;

    localparam int B_DE     = 0;
    localparam int B_DWE    = 1;
    localparam int B_FLAG0  = 4;   // flags occupy bits 7..4: cof, bof, eom, eot
    localparam int B_EOM    = 5;
    localparam int B_BOF    = 6;
    localparam int B_ST_EOM = 7;   // end-of-message bit in descriptor status
    localparam int C_ABORT  = 0;
    localparam int C_CLR    = 1;
endpackage

// File: rtl/rxdma_engine.sv
// Descriptor engine: fetches chain and buffer pointers, stores the
// received bytes, and writes back the length, then the status.
// Assumes: memory read data returns one cycle after mem_re, buflen >= 1
// and is stable during a transfer, AW <= 16, ERR_W <= 7.
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int ERR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             abort,
    input  logic             cda_wr,
    input  logic [AW-1:0]    cda_wdata,
    input  logic [AW-1:0]    eda,
    input  logic [15:0]      buflen,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic [ERR_W-1:0] rx_err,
    output logic             mem_we,
    output logic             mem_re,
    output logic [AW-1:0]    mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    output logic [AW-1:0]    cda_o,
    output logic             set_eot,
    output logic             set_eom,
    output logic             set_bof,
    output logic             frame_done
);
    eng_state_t       state;
    logic [AW-1:0]    cda, cp, bp;
    logic [15:0]      off;
    logic             last_q;
    logic [ERR_W-1:0] err_q;
    logic [15:0]      st_word;
    logic             exhausted;

    assign cda_o     = cda;
    assign exhausted = (cda == eda);

    // Assemble the status word written back to the descriptor.
    always_comb begin
        st_word           = '0;
        st_word[B_ST_EOM] = last_q;
        st_word[ERR_W-1:0] = err_q;
    end

    // Drive the memory port, the receive handshake and the event pulses per state.
    always_comb begin
        mem_we     = 1'b0;
        mem_re     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        rx_ready   = 1'b0;
        set_eot    = 1'b0;
        set_eom    = 1'b0;
        set_bof    = 1'b0;
        frame_done = 1'b0;
        case (state)
            S_IDLE:   set_bof = en && rx_valid && exhausted;
            S_RD_CP: begin
                mem_re   = 1'b1;
                mem_addr = cda;
            end
            S_RD_BP: begin
                mem_re   = 1'b1;
                mem_addr = cda + AW'(1);
            end
            S_XFER: begin
                rx_ready  = 1'b1;
                mem_we    = rx_valid;
                mem_addr  = bp + off[AW-1:0];
                mem_wdata = {8'h00, rx_data};
            end
            S_WR_LEN: begin
                mem_we    = 1'b1;
                mem_addr  = cda + AW'(2);
                mem_wdata = off;
            end
            S_WR_ST: begin
                mem_we     = 1'b1;
                mem_addr   = cda + AW'(3);
                mem_wdata  = st_word;
                set_eom    = last_q;
                frame_done = last_q;
                set_eot    = (cp == eda);
            end
            S_DROP:   rx_ready = 1'b1;
            default:  ;
        endcase
    end

    // Sequence through fetch, transfer, write-back and drop states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cda    <= '0;
            cp     <= '0;
            bp     <= '0;
            off    <= '0;
            last_q <= 1'b0;
            err_q  <= '0;
        end else if (abort) begin
            state <= S_IDLE;
        end else begin
            if (cda_wr)
                cda <= cda_wdata;
            case (state)
                S_IDLE:
                    if (en && rx_valid)
                        state <= exhausted ? S_DROP : S_RD_CP;
                S_RD_CP: state <= S_RD_BP;
                S_RD_BP: begin
                    cp    <= mem_rdata[AW-1:0];
                    state <= S_LATCH;
                end
                S_LATCH: begin
                    bp    <= mem_rdata[AW-1:0];
                    off   <= '0;
                    state <= S_XFER;
                end
                S_XFER:
                    if (rx_valid) begin
                        off <= off + 16'd1;
                        if (rx_last || (off + 16'd1 == buflen)) begin
                            last_q <= rx_last;
                            err_q  <= rx_last ? rx_err : '0;
                            state  <= S_WR_LEN;
                        end
                    end
                S_WR_LEN: state <= S_WR_ST;
                S_WR_ST: begin
                    cda   <= cp;
                    state <= S_IDLE;
                end
                S_DROP:
                    if (rx_valid && rx_last)
                        state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // A read is never followed directly by a write (pointer fetch precedes data).
    assert_read_then_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_we);

    // The buffer offset stays under the programmed buffer length while storing.
    assert_buffer_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER) |-> (off < buflen));
endmodule

// File: rtl/rxdma_regs.sv
// Register file: end address, buffer length, status flags with
// write-enable-guarded clearing, interrupt enables, frame counter and
// the abort / clear commands. Hardware flag sets win over clears.
module rxdma_regs
    import rxdma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CNT_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic [AW-1:0] cda,
    input  logic          set_eot,
    input  logic          set_eom,
    input  logic          set_bof,
    input  logic          frame_done,
    output logic          en,
    output logic          abort,
    output logic          cda_wr,
    output logic [AW-1:0] cda_wdata,
    output logic [AW-1:0] eda,
    output logic [15:0]   buflen,
    output logic          irq
);
    logic             de;
    logic [3:0]       flags;      // {cof, bof, eom, eot}
    logic             ie_eom, ie_bof;
    logic [CNT_W-1:0] cnt;
    logic             wr_dsr, clr_cnt, set_cof;
    logic [3:0]       clr_mask, set_mask;

    assign en        = de;
    assign wr_dsr    = reg_wr && (reg_addr == RA_DSR);
    assign abort     = reg_wr && (reg_addr == RA_CMD) && reg_wdata[C_ABORT];
    assign clr_cnt   = reg_wr && (reg_addr == RA_CMD) && reg_wdata[C_CLR];
    assign cda_wr    = reg_wr && (reg_addr == RA_CDA);
    assign cda_wdata = reg_wdata[AW-1:0];
    assign set_cof   = frame_done && (cnt == '1) && !clr_cnt;
    assign clr_mask  = (wr_dsr && reg_wdata[B_DWE]) ? reg_wdata[B_FLAG0+3:B_FLAG0] : 4'h0;
    assign set_mask  = {set_cof, set_bof, set_eom, set_eot};
    assign irq       = (flags[1] && ie_eom) || (flags[2] && ie_bof);

    // Hold the software registers, flags and the frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            de    <= 1'b0;
            flags <= '0;
            cnt   <= '0;
            if (!rst_n) begin
                eda    <= '0;
                buflen <= '0;
                ie_eom <= 1'b0;
                ie_bof <= 1'b0;
            end
        end else begin
            flags <= (flags & ~clr_mask) | set_mask;
            if (wr_dsr)
                de <= reg_wdata[B_DE];
            if (reg_wr && reg_addr == RA_EDA)
                eda <= reg_wdata[AW-1:0];
            if (reg_wr && reg_addr == RA_BUFLEN)
                buflen <= reg_wdata;
            if (reg_wr && reg_addr == RA_IE) begin
                ie_eom <= reg_wdata[B_EOM];
                ie_bof <= reg_wdata[B_BOF];
            end
            if (clr_cnt)
                cnt <= '0;
            else if (frame_done)
                cnt <= cnt + CNT_W'(1);
        end
    end

    // Select the register addressed for reading.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CDA:    reg_rdata = 16'(cda);
            RA_EDA:    reg_rdata = 16'(eda);
            RA_BUFLEN: reg_rdata = buflen;
            RA_DSR:    reg_rdata = {8'h00, flags, 3'b000, de};
            RA_IE:     reg_rdata = {9'b0, ie_bof, ie_eom, 5'b0};
            RA_FCNT:   reg_rdata = 16'(cnt);
            default:   reg_rdata = '0;
        endcase
    end

    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_eom && !abort) |=> flags[1]);

    assert_overflow_keeps_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bof && !abort && !wr_dsr) |=> de);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_eom || ie_bof));

    assert_counter_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && cnt == '1 && !clr_cnt && !abort) |=> (flags[3] && cnt == '0));

    assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!de && flags == '0 && cnt == '0));
endmodule

// File: rtl/chained_rx_dma.sv
// Top level of the chained descriptor receive DMA: joins the register
// file and the descriptor engine. Assumes a memory with one-cycle read
// latency and software that only writes the current address while halted.
module chained_rx_dma
    import rxdma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int ERR_W = 5,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic [ERR_W-1:0] rx_err,
    output logic             mem_we,
    output logic             mem_re,
    output logic [AW-1:0]    mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             irq
);
    logic          en, abort, cda_wr;
    logic [AW-1:0] cda_wdata, eda, cda;
    logic [15:0]   buflen;
    logic          set_eot, set_eom, set_bof, frame_done;

    rxdma_regs #(.AW(AW), .CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cda(cda), .set_eot(set_eot), .set_eom(set_eom), .set_bof(set_bof),
        .frame_done(frame_done), .en(en), .abort(abort), .cda_wr(cda_wr),
        .cda_wdata(cda_wdata), .eda(eda), .buflen(buflen), .irq(irq)
    );

    rxdma_engine #(.AW(AW), .ERR_W(ERR_W)) i_engine (
        .clk(clk), .rst_n(rst_n), .en(en), .abort(abort),
        .cda_wr(cda_wr), .cda_wdata(cda_wdata), .eda(eda), .buflen(buflen),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_last(rx_last), .rx_err(rx_err),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cda_o(cda),
        .set_eot(set_eot), .set_eom(set_eom), .set_bof(set_bof),
        .frame_done(frame_done)
    );
endmodule

// File: tb/test_chained_rx_dma.sv
`timescale 1ns/1ps
module test_chained_rx_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [4:0]  rx_err = '0;
    logic        mem_we, mem_re;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] mem [0:255];
    logic [31:0] expq [$];
    string       tagq [$];
    logic [15:0] m_cda = 16'h0000;
    logic [15:0] m_eda = 16'h0000;
    logic [15:0] m_buflen = 16'd4;

    always #5 clk = ~clk;

    chained_rx_dma i_chained_rx_dma (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Memory model: ring of four descriptors (0,4,8,C), buffers at 0x40 + 16*i.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
            for (int i = 0; i < 4; i++) begin
                mem[i*4]   <= 16'(((i + 1) % 4) * 4);
                mem[i*4+1] <= 16'(16'h40 + i * 16);
            end
        end else begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    // Scoreboard monitor: every memory write must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected write actual=%h expected none", {mem_addr, mem_wdata});
            end else begin
                logic [31:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    errors++;
                    $display("FAIL %s write actual=%h expected=%h", t, {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_eda(input logic [15:0] v);
        reg_write(3'd1, v);
        m_eda = v;
    endtask

    task automatic push(input logic [31:0] item, input string tag);
        expq.push_back(item);
        tagq.push_back(tag);
    endtask

    // Driver: predict the memory writes for a frame, then stream its bytes.
    task automatic send_frame(input int n, input logic [4:0] err, input logic [7:0] seed);
        bit need = 1;
        bit drop = 0;
        logic [15:0] cp = '0, bp = '0, off = '0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            bit last;
            b = 8'(seed + 8'(i));
            last = (i == n - 1);
            if (!drop && need) begin
                if (m_cda == m_eda) drop = 1;
                else begin
                    cp = mem[m_cda[7:0]];
                    bp = mem[m_cda[7:0] + 8'd1];
                    need = 0;
                    off = '0;
                end
            end
            if (!drop) begin
                push({16'(bp + off), 8'h00, b}, "R1");
                off = off + 16'd1;
                if (last || off == m_buflen) begin
                    push({16'(m_cda + 16'd2), off}, "R2");
                    push({16'(m_cda + 16'd3), 8'h00, last, 2'b00, (last ? err : 5'b0)},
                         last ? "R4" : "R3");
                    m_cda = cp;
                    need = 1;
                end
            end
        end
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'(seed + 8'(i));
            rx_last  = (i == n - 1);
            rx_err   = (i == n - 1) ? err : 5'b0;
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        rx_err   = '0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        reg_read(3'd0, r); chk("R11 cda", r, 16'h0000);
        reg_read(3'd3, r); chk("R11 dsr", r, 16'h0000);
        reg_read(3'd6, r); chk("R11 fcnt", r, 16'h0000);
        chk("R11 irq", 16'(irq), 16'h0000);
        chk("R11 rx_ready", 16'(rx_ready), 16'h0000);

        reg_write(3'd0, 16'h0000);
        set_eda(16'h000C);
        reg_write(3'd2, 16'd4);
        reg_write(3'd4, 16'h0060);
        reg_write(3'd3, 16'h0001);

        // Single short frame into descriptor 0
        send_frame(3, 5'b0, 8'h10);
        reg_read(3'd0, r); chk("R2 cda advanced", r, 16'h0004);
        reg_read(3'd3, r); chk("R6 eom flag", r, 16'h0021);
        chk("R8 irq on eom", 16'(irq), 16'h0001);
        reg_write(3'd3, 16'h0021);
        reg_read(3'd3, r); chk("R7 no clear without write-enable", r, 16'h0021);
        reg_write(3'd3, 16'h0023);
        reg_read(3'd3, r); chk("R7 clear with write-enable", r, 16'h0001);
        chk("R8 irq after clear", 16'(irq), 16'h0000);

        // Frame split over two descriptors, with crc error bit 4, reaching the end address
        send_frame(6, 5'b10000, 8'h30);
        reg_read(3'd0, r); chk("R2 cda at end", r, 16'h000C);
        reg_read(3'd3, r); chk("R6 eot and eom", r, 16'h0031);
        reg_write(3'd3, 16'h00F3);

        // Ring exhausted: frame dropped, overflow flag, enable kept
        send_frame(2, 5'b0, 8'h50);
        reg_read(3'd3, r); chk("R5 overflow flag, enable kept", r, 16'h0041);
        chk("R8 irq on overflow", 16'(irq), 16'h0001);
        reg_read(3'd0, r); chk("R5 cda unchanged", r, 16'h000C);
        reg_write(3'd3, 16'h00F3);

        // Resume after moving end address; frame exactly fills one buffer
        set_eda(16'h0000);
        send_frame(4, 5'b00101, 8'h70);
        reg_read(3'd3, r); chk("R3 exact fill completes", r, 16'h0031);
        reg_read(3'd6, r); chk("R9 frame count", r, 16'h0003);
        reg_write(3'd5, 16'h0002);
        reg_read(3'd6, r); chk("R9 counter cleared", r, 16'h0000);
        reg_write(3'd3, 16'h00F3);

        // Hardware set of eom in the same cycle as a software clear
        set_eda(16'h0008);
        fork
            send_frame(1, 5'b0, 8'hA0);
            begin
                do @(negedge clk); while (!(mem_we && mem_addr == 16'h0003));
                reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h0023;
                @(negedge clk);
                reg_wr = 1'b0;
            end
        join
        reg_read(3'd3, r); chk("R7 set wins over clear", r, 16'h0021);
        reg_write(3'd3, 16'h00F3);

        // Counter wrap sets counter-overflow
        for (int i = 0; i < 15; i++) begin
            set_eda(16'((m_cda + 16'd4) & 16'h000F));
            send_frame(1, 5'b0, 8'(i));
        end
        reg_read(3'd6, r); chk("R9 counter wrapped", r, 16'h0000);
        reg_read(3'd3, r); chk("R9 cof flag", r & 16'h0080, 16'h0080);

        // Abort returns to initial state; halted channel does not accept data
        reg_write(3'd5, 16'h0001);
        reg_read(3'd3, r); chk("R10 abort clears status", r, 16'h0000);
        reg_read(3'd6, r); chk("R10 abort clears counter", r, 16'h0000);
        chk("R10 irq after abort", 16'(irq), 16'h0000);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hEE; rx_last = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 halted no ready", 16'(rx_ready), 16'h0000);
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", 16'(expq.size()), 16'h0000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule